// File: doc/BRIEF.md
# Memory Cycle Type Classifier

This block sits in the bus controller of a simple processor without a cache. It labels each memory access as either a fast sequential cycle or a slower non-sequential cycle, and it gives the number of wait cycles the memory must insert for that access. The decision depends on two things beyond the current access. The first is the class of the instruction behind the previous access. The second is how far the current access sits inside a block load/store. A single history register and a small position counter carry this state from one access to the next.

Each access enters as one transfer on a valid/ready stream. A transfer carries the instruction class, a fetch-or-data flag, and a flag saying whether the address allows a sequential cycle. The classification leaves on a registered valid/ready stream.

Back-pressure follows these rules:
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle. An input transfer happens only when `in_valid` and `in_ready` are both high.
- While `out_valid` is high and `out_ready` is low, the output holds its value, and no new access is taken in.
- The history state moves forward only on accepted inputs.

Top module: `memcyc_classifier`

## Requirements
- R1: After reset, `out_valid` is low and `in_ready` is high. The first accepted fetch is non-sequential, even when it is tagged register/immediate (kind 0) and `in_seq_ok` is high.
- R2: A fetch (`in_fetch`=1) is sequential only when both of these hold: `in_seq_ok` is high, and the access accepted just before it was a fetch tagged kind 0 (register/immediate data processing).
- R3: A data access (`in_fetch`=0) tagged single load/store (kind 2) is always non-sequential. A data access tagged kind 0 or kind 1 is treated the same way.
- R4: In a run of data accesses tagged block load/store (kind 3), the first access after a fetch or after any other access is non-sequential. Each later access in the run is sequential when `in_seq_ok` is high.
- R5: A fetch is non-sequential when it follows a data access, or when it follows a fetch tagged branch (kind 1), single (kind 2) or block (kind 3).
- R6: Whenever `in_seq_ok` is low, the access is non-sequential.
- R7: `out_wait` equals SEQ_WAIT for a sequential result and SEQ_WAIT+NSEQ_EXTRA for a non-sequential one.
- R8: While `out_valid` is high and `out_ready` is low, `out_seq` and `out_wait` stay stable and `in_ready` is low. A stalled input is taken in, in order, once the output drains.
- R9: The block position counter saturates at its maximum. Block runs longer than that maximum keep giving sequential cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Access descriptor valid |
| in_ready | output | 1 | Block can take an access this cycle |
| in_kind | input | 2 | Instruction class: 0 reg/imm, 1 branch, 2 single load/store, 3 block load/store |
| in_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| in_seq_ok | input | 1 | Address allows a sequential cycle |
| out_valid | output | 1 | Classification valid |
| out_ready | input | 1 | Consumer takes the classification |
| out_seq | output | 1 | 1 = sequential cycle, 0 = non-sequential |
| out_wait | output | WAIT_W | Wait cycles to insert |

## Verification
The bench builds the block with SEQ_WAIT=1 and NSEQ_EXTRA=2, so the two wait counts differ from each other and neither one is zero. This catches a swapped or dropped offset. POS_W=3 makes the position counter saturate after seven block accesses, so a forty-beat block run covers the saturation path. Directed tasks cover each history rule and the stall behaviour. A random instruction stream is then checked against a reference classifier in the bench.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_BRANCH = 2'd1,
    K_SINGLE = 2'd2,
    K_BLOCK  = 2'd3
  } ikind_e;
endpackage

// File: rtl/memcyc_history.sv
module memcyc_history
  import memcyc_pkg::*;
#(
  parameter int POS_W = 5
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  logic   upd_fetch,
  input  ikind_e upd_kind,
  output logic   prev_alu_fetch,
  output logic   blk_active
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic [POS_W-1:0] pos_q;

  // Reset forces a non-sequential first fetch (R1).
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_alu_fetch <= 1'b0;
      pos_q          <= '0;
    end else if (upd) begin
      prev_alu_fetch <= upd_fetch && (upd_kind == K_ALU);
      if (upd_fetch || upd_kind != K_BLOCK)
        pos_q <= '0;
      else if (pos_q != POS_MAX)
        pos_q <= pos_q + 1'b1;  // saturating position counter (R9)
    end
  end

  assign blk_active = (pos_q != '0);

  p_pos_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && upd_fetch) |=> !blk_active);
  p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !upd_fetch && upd_kind == K_BLOCK && blk_active) |=> blk_active);
endmodule

// File: rtl/memcyc_decide.sv
module memcyc_decide
  import memcyc_pkg::*;
#(
  parameter int SEQ_WAIT   = 0,
  parameter int NSEQ_EXTRA = 1,
  parameter int WAIT_W     = 4
) (
  input  logic              is_fetch,
  input  ikind_e            kind,
  input  logic              seq_ok,
  input  logic              prev_alu_fetch,
  input  logic              blk_active,
  output logic              seq,
  output logic [WAIT_W-1:0] wait_cnt
);
  localparam logic [WAIT_W-1:0] W_SEQ  = WAIT_W'(SEQ_WAIT);
  localparam logic [WAIT_W-1:0] W_NSEQ = WAIT_W'(SEQ_WAIT + NSEQ_EXTRA);

  logic allowed;

  always_comb begin
    if (is_fetch)
      allowed = prev_alu_fetch;
    else if (kind == K_BLOCK)
      allowed = blk_active;
    else
      allowed = 1'b0;
    seq      = allowed && seq_ok;
    wait_cnt = seq ? W_SEQ : W_NSEQ;
  end
endmodule

// File: rtl/memcyc_classifier.sv
module memcyc_classifier
  import memcyc_pkg::*;
#(
  parameter int SEQ_WAIT   = 0,
  parameter int NSEQ_EXTRA = 1,
  parameter int WAIT_W     = 4,
  parameter int POS_W      = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_kind,
  input  logic              in_fetch,
  input  logic              in_seq_ok,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_seq,
  output logic [WAIT_W-1:0] out_wait
);
  localparam logic [WAIT_W-1:0] W_SEQ  = WAIT_W'(SEQ_WAIT);
  localparam logic [WAIT_W-1:0] W_NSEQ = WAIT_W'(SEQ_WAIT + NSEQ_EXTRA);

  ikind_e            kind;
  logic              take;
  logic              prev_alu_fetch;
  logic              blk_active;
  logic              d_seq;
  logic [WAIT_W-1:0] d_wait;

  assign kind     = ikind_e'(in_kind);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  memcyc_history #(.POS_W(POS_W)) u_hist (
    .clk            (clk),
    .rst_n          (rst_n),
    .upd            (take),
    .upd_fetch      (in_fetch),
    .upd_kind       (kind),
    .prev_alu_fetch (prev_alu_fetch),
    .blk_active     (blk_active)
  );

  memcyc_decide #(
    .SEQ_WAIT   (SEQ_WAIT),
    .NSEQ_EXTRA (NSEQ_EXTRA),
    .WAIT_W     (WAIT_W)
  ) u_dec (
    .is_fetch       (in_fetch),
    .kind           (kind),
    .seq_ok         (in_seq_ok),
    .prev_alu_fetch (prev_alu_fetch),
    .blk_active     (blk_active),
    .seq            (d_seq),
    .wait_cnt       (d_wait)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_seq   <= 1'b0;
      out_wait  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_seq  <= d_seq;
        out_wait <= d_wait;
      end
    end
  end

  p_single_nseq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_fetch && kind != K_BLOCK) |=> (out_valid && !out_seq));
  p_no_seq_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_seq_ok) |=> (out_valid && !out_seq));
  p_wait_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_wait == (out_seq ? W_SEQ : W_NSEQ)));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_seq) && $stable(out_wait)));
  p_nonalu_fetch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_fetch && kind != K_ALU) |=> !prev_alu_fetch);
endmodule

// File: tb/test_memcyc_classifier.sv
module test_memcyc_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int SEQ_WAIT   = 1;
  localparam int NSEQ_EXTRA = 2;
  localparam int WAIT_W     = 3;
  localparam int POS_W      = 3;
  localparam logic [WAIT_W-1:0] WS = WAIT_W'(SEQ_WAIT);
  localparam logic [WAIT_W-1:0] WN = WAIT_W'(SEQ_WAIT + NSEQ_EXTRA);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_kind = 2'd0;
  logic in_fetch = 1'b0;
  logic in_seq_ok = 1'b0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_seq;
  logic [WAIT_W-1:0] out_wait;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference history
  bit m_prev_alu_fetch = 1'b0;
  bit m_in_block = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memcyc_classifier #(
    .SEQ_WAIT(SEQ_WAIT), .NSEQ_EXTRA(NSEQ_EXTRA), .WAIT_W(WAIT_W), .POS_W(POS_W)
  ) i_memcyc_classifier (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_fetch(in_fetch), .in_seq_ok(in_seq_ok),
    .out_valid(out_valid), .out_ready(out_ready), .out_seq(out_seq), .out_wait(out_wait)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit ref_seq(input logic [1:0] k, input bit f, input bit ok);
    if (!ok) return 1'b0;
    if (f) return m_prev_alu_fetch;
    if (k == 2'd3) return m_in_block;
    return 1'b0;
  endfunction

  function automatic void ref_upd(input logic [1:0] k, input bit f);
    m_prev_alu_fetch = f && (k == 2'd0);
    m_in_block = !f && (k == 2'd3);
  endfunction

  // one access with out_ready high; checks the classification
  task automatic access(input string req, input logic [1:0] k, input bit f, input bit ok);
    bit e;
    e = ref_seq(k, f, ok);
    ref_upd(k, f);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_fetch = f; in_seq_ok = ok;
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " valid"}, int'(out_valid), 1);
    chk({req, " seq"}, int'(out_seq), int'(e));
    chk({req, " R7 wait"}, int'(out_wait), int'(e ? WS : WN));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_prev_alu_fetch = 1'b0;
    m_in_block = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);
    access("R1 first fetch", 2'd0, 1'b1, 1'b1);
  endtask

  task automatic t_fetch_history();
    do_reset();
    access("R2 f0", 2'd0, 1'b1, 1'b1);
    access("R2 alu chain", 2'd0, 1'b1, 1'b1);
    access("R2 alu chain2", 2'd0, 1'b1, 1'b1);
    access("R5 branch fetch", 2'd1, 1'b1, 1'b1);
    access("R5 after branch", 2'd0, 1'b1, 1'b1);
    access("R2 recovered", 2'd0, 1'b1, 1'b1);
    access("R3 single data", 2'd2, 1'b0, 1'b1);
    access("R5 after data", 2'd2, 1'b1, 1'b1);
    access("R5 after single fetch", 2'd0, 1'b1, 1'b1);
    access("R6 no seq ok", 2'd0, 1'b1, 1'b0);
    access("R3 kind0 data", 2'd0, 1'b0, 1'b1);
  endtask

  task automatic t_block();
    do_reset();
    access("R4 pre", 2'd0, 1'b1, 1'b1);
    access("R4 first beat", 2'd3, 1'b0, 1'b1);
    access("R4 second beat", 2'd3, 1'b0, 1'b1);
    access("R6 beat no ok", 2'd3, 1'b0, 1'b0);
    access("R4 third beat", 2'd3, 1'b0, 1'b1);
    access("R5 fetch after block", 2'd3, 1'b1, 1'b1);
    access("R4 new block first", 2'd3, 1'b0, 1'b1);
    for (int i = 0; i < 40; i++) access("R9 long block", 2'd3, 1'b0, 1'b1);
    access("R4 single breaks run", 2'd2, 1'b0, 1'b1);
    access("R4 block after single", 2'd3, 1'b0, 1'b1);
  endtask

  task automatic t_stall();
    bit ea, eb;
    do_reset();
    access("R8 pre", 2'd0, 1'b1, 1'b1);
    ea = ref_seq(2'd0, 1'b1, 1'b1); ref_upd(2'd0, 1'b1);
    eb = ref_seq(2'd1, 1'b1, 1'b1); ref_upd(2'd1, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_kind = 2'd0; in_fetch = 1'b1; in_seq_ok = 1'b1;
    @(negedge clk);
    in_kind = 2'd1;  // second access, stalled
    for (int i = 0; i < 3; i++) begin
      chk("R8 held valid", int'(out_valid), 1);
      chk("R8 held seq", int'(out_seq), int'(ea));
      chk("R8 ready low", int'(in_ready), 0);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 second valid", int'(out_valid), 1);
    chk("R8 second seq", int'(out_seq), int'(eb));
    @(negedge clk);
    chk("R8 drained", int'(out_valid), 0);
  endtask

  task automatic t_random();
    do_reset();
    for (int i = 0; i < 300; i++)
      access("R2-rand", 2'($urandom_range(3)), 1'($urandom_range(1)), ($urandom_range(3) != 0));
  endtask

  initial begin
    t_reset();
    t_fetch_history();
    t_block();
    t_stall();
    t_random();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule